// File: doc/BRIEF.md
# Timer Event Flag and Interrupt Request Unit

This block holds the three event flags of a 16-bit timer: capture, compare and overflow. The timer delivers single-cycle pulses for each event. A pulse sets the matching sticky flag. Software reads the flags through a byte-wide register at a fixed address and clears any of them by writing a one to that flag's bit.

Each flag also clears by hardware when the interrupt controller acknowledges that source. Each source drives its own level interrupt request. A request is high only while its flag is set, its mask bit is set and the global enable is set.

The compare flag lags the match indication by one clock. The capture and overflow flags take effect at the first edge after their strobe. When a hardware set and a clear reach the same flag in one cycle, the set wins, so no event is lost.

Top module: `timer_irq_flags`

## Requirements
- R1: After reset is released, all three flags are zero, a read of the flag register returns 8'h00 and all interrupt requests are low.
- R2: A read at address 8'h17 returns the byte {5'b00000, capture flag, compare flag, overflow flag}, with the capture flag in bit 2, the compare flag in bit 1 and the overflow flag in bit 0. Bits 7 to 3 always read zero. A read at any other address, or with the read strobe low, returns 8'h00.
- R3: A capture strobe high at a clock edge makes the capture flag (bit 2) read as one from that edge on.
- R4: A compare-match indication high at a clock edge does not change the compare flag (bit 1) at that edge. The flag reads as one from the following edge on.
- R5: An overflow pulse high at a clock edge makes the overflow flag (bit 0) read as one from that edge on.
- R6: A write at address 8'h17 clears every flag whose data bit is one and leaves a flag unchanged where its data bit is zero. Data bits 7 to 3 have no effect, and writes at any other address change no flag.
- R7: Acknowledge bit 2 clears the capture flag, bit 1 clears the compare flag and bit 0 clears the overflow flag, each at the clock edge where the acknowledge bit is high.
- R8: When a set event and a clear (by write or by acknowledge) reach the same flag at the same edge, the flag is one after that edge.
- R9: Each interrupt request is a level that equals its flag AND its mask bit AND the global enable. Mask bit 2 gates capture, bit 1 gates compare and bit 0 gates overflow. The request follows changes of the mask or the enable in the same cycle.
- R10: A read returns the flags as held before the edge that closes the read cycle. A set or clear in the same cycle is not yet visible to that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_evt_i | input | 1 | Capture strobe from the timer |
| cmp_match_i | input | 1 | Compare-match indication from the timer |
| ovf_evt_i | input | 1 | Overflow pulse at maximum count |
| irq_mask_i | input | 3 | Per-source mask: bit 2 capture, bit 1 compare, bit 0 overflow |
| irq_gen_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 3 | Per-source acknowledge pulse, same bit order as the mask |
| bus_addr_i | input | 8 | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational |
| irq_cap_o | output | 1 | Capture interrupt request |
| irq_cmp_o | output | 1 | Compare interrupt request |
| irq_ovf_o | output | 1 | Overflow interrupt request |

## Verification
The properties assume that every input is a clean synchronous level, sampled at the rising edge. They make no assumption about pulse width or spacing. Events, writes and acknowledges may overlap in any combination.

The clear properties exclude a simultaneous set, because the set has priority in that case. The compare clear property also excludes a match in the previous cycle, since that match is still waiting in the delay stage.

The random stimulus draws every input freely each cycle. Writes and acknowledges are kept rare so that flags stay set long enough to be observed. The address points at the flag register most of the time, with stray addresses mixed in.

// File: rtl/tif_pkg.sv
// Package: shared constants and source indices for the timer flag unit.
// Assumes three event sources in a fixed bit order inside the flag byte.
package tif_pkg;

    localparam int SRC_N = 3;

    // Bit positions of the sources inside the flag byte.
    typedef enum int unsigned {
        SRC_OVF = 0,
        SRC_CMP = 1,
        SRC_CAP = 2
    } src_e;

endpackage

// File: rtl/tif_event_delay.sv
// Module: tif_event_delay
// Delays an event strobe by LAG clock cycles. LAG = 0 passes it through.
// Assumes a synchronous active-low reset that clears any pending strobes.
module tif_event_delay #(
    parameter int LAG = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    output logic evt_o
);

    generate
        if (LAG == 0) begin : g_pass
            // Purpose: forward the strobe with no delay.
            assign evt_o = evt_i;
        end else begin : g_shift
            logic [LAG-1:0] pipe_q;

            // Purpose: shift the strobe through LAG stages.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pipe_q <= '0;
                end else if (LAG == 1) begin
                    pipe_q[0] <= evt_i;
                end else begin
                    pipe_q <= {pipe_q[LAG-2:0], evt_i};
                end
            end

            assign evt_o = pipe_q[LAG-1];
        end
    endgenerate

endmodule

// File: rtl/tif_flag_cell.sv
// Module: tif_flag_cell
// One sticky flag bit. A set has priority over a clear at the same edge.
// Assumes set_i and clr_i are synchronous single-bit levels.
module tif_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_q
);

    // Purpose: hold the flag, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/tif_reg_port.sv
// Module: tif_reg_port
// Decodes the flag register address. Builds the write-one clear vector and
// the combinational read byte, with the reserved upper bits read as zero.
// Assumes DATA_W >= SRC_N.
module tif_reg_port #(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 8,
    parameter int          SRC_N    = 3,
    parameter logic [7:0]  REG_ADDR = 8'h17
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic              re_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [SRC_N-1:0]  flags_i,
    output logic [SRC_N-1:0]  wclr_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int RSV_W = DATA_W - SRC_N;

    logic hit;

    // Purpose: match the bus address against the register address.
    always_comb begin
        hit = (addr_i == ADDR_W'(REG_ADDR));
    end

    // Purpose: a written one clears a flag; reserved data bits are dropped.
    always_comb begin
        wclr_o = (we_i && hit) ? wdata_i[SRC_N-1:0] : '0;
    end

    // Purpose: return the held flags; reserved bits read as zero.
    always_comb begin
        if (re_i && hit) begin
            rdata_o = {{RSV_W{1'b0}}, flags_i};
        end else begin
            rdata_o = '0;
        end
    end

endmodule

// File: rtl/tif_irq_gate.sv
// Module: tif_irq_gate
// Gates each flag with its mask bit and the global enable to form the
// level interrupt requests. Purely combinational.
module tif_irq_gate #(
    parameter int SRC_N = 3
) (
    input  logic [SRC_N-1:0] flags_i,
    input  logic [SRC_N-1:0] mask_i,
    input  logic             gen_i,
    output logic [SRC_N-1:0] irq_o
);

    // Purpose: form each request level from flag, mask and enable.
    always_comb begin
        for (int i = 0; i < SRC_N; i++) begin
            irq_o[i] = flags_i[i] & mask_i[i] & gen_i;
        end
    end

endmodule

// File: rtl/timer_irq_flags.sv
// Module: timer_irq_flags
// Flag and interrupt request unit for a 16-bit timer. It holds the capture,
// compare and overflow flags. Each flag clears by a write of one or by its
// acknowledge pulse, and each drives a gated level interrupt request.
// Assumes all inputs are synchronous to clk and the reset is synchronous
// and active low.
module timer_irq_flags #(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  REG_ADDR = 8'h17,
    parameter int          CMP_LAG  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_evt_i,
    input  logic              cmp_match_i,
    input  logic              ovf_evt_i,
    input  logic [2:0]        irq_mask_i,
    input  logic              irq_gen_i,
    input  logic [2:0]        irq_ack_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic              bus_re_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_cap_o,
    output logic              irq_cmp_o,
    output logic              irq_ovf_o
);

    import tif_pkg::*;

    logic [SRC_N-1:0] raw_evt;
    logic [SRC_N-1:0] set_evt;
    logic [SRC_N-1:0] wclr;
    logic [SRC_N-1:0] flag_q;
    logic [SRC_N-1:0] irq;

    // Purpose: collect the raw event strobes in flag-bit order.
    always_comb begin
        raw_evt          = '0;
        raw_evt[SRC_OVF] = ovf_evt_i;
        raw_evt[SRC_CMP] = cmp_match_i;
        raw_evt[SRC_CAP] = cap_evt_i;
    end

    // Per source: an alignment stage (a lag only on compare) and a flag cell.
    generate
        for (genvar s = 0; s < SRC_N; s++) begin : g_src
            localparam int LAG = (s == int'(SRC_CMP)) ? CMP_LAG : 0;

            tif_event_delay #(.LAG(LAG)) u_dly (
                .clk   (clk),
                .rst_n (rst_n),
                .evt_i (raw_evt[s]),
                .evt_o (set_evt[s])
            );

            tif_flag_cell u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (set_evt[s]),
                .clr_i  (wclr[s] | irq_ack_i[s]),
                .flag_q (flag_q[s])
            );
        end
    endgenerate

    tif_reg_port #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SRC_N    (SRC_N),
        .REG_ADDR (REG_ADDR)
    ) u_port (
        .addr_i  (bus_addr_i),
        .we_i    (bus_we_i),
        .re_i    (bus_re_i),
        .wdata_i (bus_wdata_i),
        .flags_i (flag_q),
        .wclr_o  (wclr),
        .rdata_o (bus_rdata_o)
    );

    tif_irq_gate #(.SRC_N(SRC_N)) u_gate (
        .flags_i (flag_q),
        .mask_i  (irq_mask_i),
        .gen_i   (irq_gen_i),
        .irq_o   (irq)
    );

    assign irq_ovf_o = irq[SRC_OVF];
    assign irq_cmp_o = irq[SRC_CMP];
    assign irq_cap_o = irq[SRC_CAP];

endmodule

// File: rtl/tif_checker.sv
// Module: tif_checker
// Temporal properties of the timer flag unit. It is attached to the top
// module by the bind statement at the end of this file.
module tif_checker #(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  REG_ADDR = 8'h17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cap_evt_i,
    input logic              cmp_match_i,
    input logic              ovf_evt_i,
    input logic [2:0]        irq_mask_i,
    input logic              irq_gen_i,
    input logic [2:0]        irq_ack_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              bus_we_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic [DATA_W-1:0] bus_rdata_o,
    input logic [2:0]        flags,
    input logic [2:0]        irq
);

    logic hit_w;
    assign hit_w = bus_we_i && (bus_addr_i == ADDR_W'(REG_ADDR));

    // R2: reserved bits never read as one.
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata_o[DATA_W-1:3] == '0);

    // R3: capture strobe sets bit 2.
    p_cap_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt_i |=> flags[2]);

    // R4: compare flag appears one cycle after the match.
    p_cmp_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_match_i |=> ##1 flags[1]);

    // R5: overflow pulse sets bit 0.
    p_ovf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt_i |=> flags[0]);

    // R6: a written one clears the overflow flag when no set competes.
    p_w1c_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_w && bus_wdata_i[0] && !ovf_evt_i) |=> !flags[0]);

    // R6: a write at another address leaves the capture flag unchanged.
    p_stray_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_w && irq_ack_i == 3'b000 && !cap_evt_i) |=> $stable(flags[2]));

    // R7: acknowledge clears the capture flag when no set competes.
    p_ack_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_i[2] && !cap_evt_i) |=> !flags[2]);

    // R7: acknowledge clears the compare flag when no delayed set competes.
    p_ack_cmp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_i[1] && !$past(cmp_match_i)) |=> !flags[1]);

    // R8: overflow set wins over a same-edge acknowledge.
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt_i && irq_ack_i[0]) |=> flags[0]);

    // R9: no request without the global enable.
    p_gen_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_gen_i |-> (irq == 3'b000));

    // R9: no request on a masked source.
    p_mask_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~irq_mask_i) == 3'b000);

endmodule

bind timer_irq_flags tif_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .REG_ADDR (REG_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_evt_i   (cap_evt_i),
    .cmp_match_i (cmp_match_i),
    .ovf_evt_i   (ovf_evt_i),
    .irq_mask_i  (irq_mask_i),
    .irq_gen_i   (irq_gen_i),
    .irq_ack_i   (irq_ack_i),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .flags       (flag_q),
    .irq         ({irq_cap_o, irq_cmp_o, irq_ovf_o})
);

// File: tb/timer_irq_flags_test.sv
module timer_irq_flags_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] RADDR = 8'h17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cap_evt_i = 1'b0, cmp_match_i = 1'b0, ovf_evt_i = 1'b0;
    logic [2:0] irq_mask_i = '0;
    logic       irq_gen_i = 1'b0;
    logic [2:0] irq_ack_i = '0;
    logic [7:0] bus_addr_i = '0;
    logic       bus_we_i = 1'b0, bus_re_i = 1'b0;
    logic [7:0] bus_wdata_i = '0;
    logic [7:0] bus_rdata_o;
    logic       irq_cap_o, irq_cmp_o, irq_ovf_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference state.
    logic [2:0] m_flags = '0;
    logic       m_cmp_pend = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    timer_irq_flags uut (
        .clk(clk), .rst_n(rst_n),
        .cap_evt_i(cap_evt_i), .cmp_match_i(cmp_match_i), .ovf_evt_i(ovf_evt_i),
        .irq_mask_i(irq_mask_i), .irq_gen_i(irq_gen_i), .irq_ack_i(irq_ack_i),
        .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i), .bus_re_i(bus_re_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .irq_cap_o(irq_cap_o), .irq_cmp_o(irq_cmp_o), .irq_ovf_o(irq_ovf_o)
    );

    function automatic logic [7:0] exp_rdata();
        return (bus_re_i && bus_addr_i == RADDR) ? {5'b0, m_flags} : 8'h00;
    endfunction

    function automatic logic [2:0] exp_irq();
        return m_flags & irq_mask_i & {3{irq_gen_i}};
    endfunction

    function automatic logic [2:0] exp_next();
        logic [2:0] clr;
        logic [2:0] nxt;
        clr = ((bus_we_i && bus_addr_i == RADDR) ? bus_wdata_i[2:0] : 3'b000) | irq_ack_i;
        nxt = (m_flags & ~clr) | {cap_evt_i, m_cmp_pend, ovf_evt_i};
        return nxt;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic cap, input logic cmp, input logic ovf,
                         input logic [2:0] msk, input logic gen, input logic [2:0] ack,
                         input logic [7:0] addr, input logic we, input logic re,
                         input logic [7:0] wd);
        cap_evt_i = cap; cmp_match_i = cmp; ovf_evt_i = ovf;
        irq_mask_i = msk; irq_gen_i = gen; irq_ack_i = ack;
        bus_addr_i = addr; bus_we_i = we; bus_re_i = re; bus_wdata_i = wd;
    endtask

    // One cycle: inputs already driven at negedge; check comb outputs, then clock.
    task automatic cycle(input string tag);
        #1;
        check({tag, " rdata R2/R10"}, bus_rdata_o, exp_rdata());
        check({tag, " irq R9"}, {5'b0, irq_cap_o, irq_cmp_o, irq_ovf_o}, {5'b0, exp_irq()});
        @(posedge clk);
        m_flags = exp_next();
        m_cmp_pend = cmp_match_i;
        @(negedge clk);
    endtask

    task automatic idle_read(input string tag);
        drive(0, 0, 0, 3'b111, 1, 3'b000, RADDR, 0, 1, 8'h00);
        cycle(tag);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        drive(0, 0, 0, 3'b111, 1, 3'b000, RADDR, 0, 1, 8'h00);
        #1;
        check("R1 reset rdata", bus_rdata_o, 8'h00);
        check("R1 reset irq", {5'b0, irq_cap_o, irq_cmp_o, irq_ovf_o}, 8'h00);

        // R3 and R10: capture strobe, same-cycle read still shows old value.
        drive(1, 0, 0, 3'b111, 1, 3'b000, RADDR, 0, 1, 8'h00);
        #1;
        check("R10 same-cycle read", bus_rdata_o, 8'h00);
        cycle("R3 cap");
        #1;
        check("R3 cap visible", bus_rdata_o, 8'h04);
        idle_read("R3 hold");

        // R4: compare lag of one cycle.
        drive(0, 1, 0, 3'b111, 1, 3'b000, RADDR, 0, 1, 8'h00);
        cycle("R4 match");
        #1;
        check("R4 not yet set", bus_rdata_o, 8'h04);
        idle_read("R4 delay");
        #1;
        check("R4 set after lag", bus_rdata_o, 8'h06);

        // R5: overflow.
        drive(0, 0, 1, 3'b111, 1, 3'b000, RADDR, 0, 1, 8'h00);
        cycle("R5 ovf");
        #1;
        check("R5 ovf visible", bus_rdata_o, 8'h07);

        // R2: other address reads zero.
        drive(0, 0, 0, 3'b111, 1, 3'b000, 8'h18, 0, 1, 8'h00);
        cycle("R2 other addr");

        // R6: stray-address write and reserved-bit write have no effect.
        drive(0, 0, 0, 3'b111, 1, 3'b000, 8'h16, 1, 0, 8'hFF);
        cycle("R6 stray write");
        drive(0, 0, 0, 3'b111, 1, 3'b000, RADDR, 1, 0, 8'hF8);
        cycle("R6 reserved write");
        #1;
        check("R6 no effect", bus_rdata_o, 8'h00);
        bus_re_i = 1;
        #1;
        check("R6 flags kept", bus_rdata_o, 8'h07);
        // R6: write one clears bit 1 only.
        drive(0, 0, 0, 3'b111, 1, 3'b000, RADDR, 1, 0, 8'h02);
        cycle("R6 w1c");
        bus_re_i = 1;
        #1;
        check("R6 w1c result", bus_rdata_o, 8'h05);

        // R7: acknowledge clears capture.
        drive(0, 0, 0, 3'b111, 1, 3'b100, RADDR, 0, 1, 8'h00);
        cycle("R7 ack");
        bus_re_i = 1;
        #1;
        check("R7 ack result", bus_rdata_o, 8'h01);

        // R8: set wins over write-one and acknowledge on overflow.
        drive(0, 0, 1, 3'b111, 1, 3'b001, RADDR, 1, 0, 8'h01);
        cycle("R8 set wins");
        bus_re_i = 1;
        #1;
        check("R8 flag stays", bus_rdata_o, 8'h01);

        // R9: mask and enable gating.
        drive(0, 0, 0, 3'b000, 1, 3'b000, RADDR, 0, 1, 8'h00);
        cycle("R9 masked");
        drive(0, 0, 0, 3'b111, 0, 3'b000, RADDR, 0, 1, 8'h00);
        cycle("R9 disabled");
        drive(0, 0, 0, 3'b001, 1, 3'b000, RADDR, 0, 1, 8'h00);
        #1;
        check("R9 ovf request", {7'b0, irq_ovf_o}, 8'h01);

        // Constrained random mix.
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a;
            a = ($urandom_range(0, 9) < 8) ? RADDR : 8'($urandom);
            drive(1'($urandom_range(0, 5) == 0), 1'($urandom_range(0, 5) == 0),
                  1'($urandom_range(0, 5) == 0), 3'($urandom), 1'($urandom_range(0, 3) != 0),
                  ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'b000,
                  a, 1'($urandom_range(0, 7) == 0), 1'($urandom), 8'($urandom));
            cycle("random R3 R4 R5 R6 R7 R8");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule